// File: doc/BRIEF.md
# USB OUT Endpoint Status Controller

This block holds the control and status state of a single double-buffered USB OUT endpoint. The function controller side reports events to it as single-cycle pulses. These events are the start of an OUT token, a packet that completed without error together with its data PID, a packet longer than the maximum packet size, and a bit-stuffing or CRC error on an isochronous packet. A level input marks a reception that is still in progress.

From these events the block keeps four pieces of state. The first is a count of stored data sets, which is 0, 1 or 2. The second is three sticky error flags. The third is a STALL request. The fourth is the data toggle it expects next.

Software drives the block through a write port of write-one command bits and reads its state through a status vector. The combinational `rx_store` output tells the packet storage when to commit the packet being received. Packet storage, the serial engine and the transceiver sit outside this block.

Top module: `usb_out_ep_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all six bits of `rd_status` are 0. The stored-set count is zero, the flags are clear and the expected toggle is DATA0.
- R2: The `rd_status` layout is as follows. Bit 0 is 1 only when two sets are stored. Bit 1 is 1 when at least one set is stored. Bit 2 is overrun, bit 3 is force-stall and bit 4 is data-error. Bit 5 is the expected toggle, with 0 meaning DATA0 and 1 meaning DATA1.
- R3: A packet is accepted when `rx_ok` is high, `rx_pid1` equals the expected toggle, and either a slot is free or a set is released in the same cycle. On acceptance `rx_store` is 1 in that cycle. From the next cycle the count is one higher and the expected toggle is inverted.
- R4: A packet whose PID does not match the expected toggle gives `rx_store` 0. It leaves the count and the toggle unchanged.
- R5: A matching packet that arrives with both slots full and no release in that cycle is dropped. `rx_store` is 0 and the count and toggle are unchanged.
- R6: A write with bit 0 (unload done) set removes one set when at least one set is stored. The write is ignored when the buffer is empty.
- R7: A write with bit 5 (flush) set removes the oldest set, which empties a single stored set or leaves one of two. The flush is ignored when the buffer is empty or while `rx_busy` is high.
- R8: A reception accepted in the same cycle as an honoured unload or flush leaves the count unchanged, and the expected toggle still inverts.
- R9: While `cfg_iso` is 1, an OUT token start with two sets stored sets the overrun flag. The flag is not set in bulk mode or with fewer sets stored. Write bit 1 clears it, and a set in the same cycle wins over the clear.
- R10: A packet longer than the maximum packet size sets the force-stall flag. `hs_stall` is 1 while the flag is set. Write bit 2 clears the flag, and a set wins over the clear.
- R11: A bit-stuffing or CRC error pulse sets the data-error flag only while `cfg_iso` is 1. Write bit 3 clears it, and a set wins over the clear.
- R12: Write bit 4 forces the expected toggle to DATA0 in the next cycle. This holds even if a packet is accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_iso | input | 1 | Endpoint is in isochronous mode |
| tok_start | input | 1 | Pulse at the start of an OUT token |
| rx_ok | input | 1 | Pulse when a packet completed without error |
| rx_pid1 | input | 1 | Data PID of the completed packet (1 = DATA1) |
| rx_too_long | input | 1 | Pulse for a packet longer than the maximum size |
| rx_iso_err | input | 1 | Pulse for a bit-stuffing or CRC error |
| rx_busy | input | 1 | A reception is in progress |
| wr_en | input | 1 | CPU command write strobe |
| wr_data | input | 6 | Write-one command bits |
| rd_status | output | 6 | Status vector |
| rx_store | output | 1 | Commit the current packet to storage |
| hs_stall | output | 1 | Answer the transaction with STALL |

## Verification
The assertions assume that every event input is a synchronous single-cycle pulse. They also assume that `rx_ok` and `rx_too_long` never arrive together, because an oversized packet is not a successful reception. The bench drives all inputs on the falling edge. Its random generator masks `rx_ok` whenever it draws an oversized packet, and it draws the PID with a bias toward the expected toggle so that acceptances, mismatches and full-buffer drops all occur.

// File: rtl/ep_pkg.sv
// Package: shared constants and types for the OUT endpoint status controller.
// Assumes a two-slot buffer; the command and status bit positions below are
// the software-visible layout.
package ep_pkg;
    localparam int unsigned SLOTS    = 2;
    localparam int unsigned OCC_W    = $clog2(SLOTS + 1);
    localparam int unsigned CMD_W    = 6;
    localparam int unsigned STS_W    = 6;
    localparam int unsigned FLAG_N   = 3;

    // command bit positions
    localparam int unsigned CMD_UNLOAD   = 0;
    localparam int unsigned CMD_CLR_BASE = 1;   // clears for flags 0..FLAG_N-1
    localparam int unsigned CMD_TOG_INIT = 4;
    localparam int unsigned CMD_FLUSH    = 5;

    // flag indices (status bit = STS_FLAG_BASE + index)
    localparam int unsigned FLAG_OVR      = 0;
    localparam int unsigned FLAG_STALL    = 1;
    localparam int unsigned FLAG_DERR     = 2;
    localparam int unsigned STS_FULL      = 0;
    localparam int unsigned STS_ANY       = 1;
    localparam int unsigned STS_FLAG_BASE = 2;
    localparam int unsigned STS_TOG       = 5;

    typedef logic [OCC_W-1:0] occ_t;
endpackage

// File: rtl/ep_sticky_flag.sv
// Module: one sticky status flag with a write-one clear.
// Assumes set and clear are single-cycle strobes; a set wins over a clear.
module ep_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // hold the flag until software clears it
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (set_i)  flag_o <= 1'b1;
        else if (clr_i)  flag_o <= 1'b0;
    end

    // R9 R10 R11: a set event is visible in the following cycle
    p_set_sticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    // R9 R10 R11: a clear with no set drops the flag
    p_clr_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/ep_occ_track.sv
// Module: occupancy counter for the two-slot OUT buffer.
// Decides whether a packet is accepted and whether a set is released.
// Assumes rx_ok_i is a one-cycle pulse and pid_match_i is valid with it.
module ep_occ_track
    import ep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_ok_i,
    input  logic pid_match_i,
    input  logic unload_i,
    input  logic flush_i,
    input  logic rx_busy_i,
    output occ_t occ_o,
    output logic accept_o,
    output logic release_o
);
    localparam occ_t OCC_FULL = occ_t'(SLOTS);

    logic has_data;
    logic full;
    occ_t occ_nxt;

    // decode release and acceptance from the current count
    always_comb begin
        has_data  = (occ_o != '0);
        full      = (occ_o == OCC_FULL);
        release_o = has_data && (unload_i || (flush_i && !rx_busy_i));
        accept_o  = rx_ok_i && pid_match_i && (!full || release_o);
        occ_nxt   = occ_o;
        if (accept_o && !release_o)      occ_nxt = occ_o + occ_t'(1);
        else if (!accept_o && release_o) occ_nxt = occ_o - occ_t'(1);
    end

    // count register
    always_ff @(posedge clk) begin
        if (!rst_n) occ_o <= '0;
        else        occ_o <= occ_nxt;
    end

    p_occ_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        occ_o <= OCC_FULL);
    p_occ_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept_o && !release_o) |=> $stable(occ_o));
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |-> (occ_o != '0));
endmodule

// File: rtl/ep_toggle_track.sv
// Module: expected data toggle (0 = DATA0, 1 = DATA1).
// Assumes accept_i pulses once per stored packet; an initialise wins over a flip.
module ep_toggle_track (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    input  logic init_i,
    output logic exp_o
);
    // track the next expected PID
    always_ff @(posedge clk) begin
        if (!rst_n)        exp_o <= 1'b0;
        else if (init_i)   exp_o <= 1'b0;
        else if (accept_i) exp_o <= ~exp_o;
    end

    p_init_data0_r12: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> !exp_o);
    p_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && !init_i) |=> (exp_o != $past(exp_o)));
endmodule

// File: rtl/usb_out_ep_ctrl.sv
// Module: control and status state for one double-buffered USB OUT endpoint.
// Assumes all event inputs are synchronous one-cycle pulses and that
// rx_ok and rx_too_long never coincide.
module usb_out_ep_ctrl
    import ep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_iso,
    input  logic             tok_start,
    input  logic             rx_ok,
    input  logic             rx_pid1,
    input  logic             rx_too_long,
    input  logic             rx_iso_err,
    input  logic             rx_busy,
    input  logic             wr_en,
    input  logic [CMD_W-1:0] wr_data,
    output logic [STS_W-1:0] rd_status,
    output logic             rx_store,
    output logic             hs_stall
);
    logic [CMD_W-1:0]  cmd;
    logic [FLAG_N-1:0] flag_set;
    logic [FLAG_N-1:0] flag_q;
    logic              exp_tog;
    logic              accept;
    logic              release_w;
    occ_t              occ;

    // qualify command bits with the write strobe
    assign cmd = wr_en ? wr_data : '0;

    ep_occ_track u_occ (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_ok_i     (rx_ok),
        .pid_match_i (rx_pid1 == exp_tog),
        .unload_i    (cmd[CMD_UNLOAD]),
        .flush_i     (cmd[CMD_FLUSH]),
        .rx_busy_i   (rx_busy),
        .occ_o       (occ),
        .accept_o    (accept),
        .release_o   (release_w)
    );

    ep_toggle_track u_tog (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .init_i   (cmd[CMD_TOG_INIT]),
        .exp_o    (exp_tog)
    );

    // set conditions for the sticky flags
    always_comb begin
        flag_set             = '0;
        flag_set[FLAG_OVR]   = tok_start && cfg_iso && (occ == occ_t'(SLOTS));
        flag_set[FLAG_STALL] = rx_too_long;
        flag_set[FLAG_DERR]  = rx_iso_err && cfg_iso;
    end

    for (genvar gi = 0; gi < FLAG_N; gi++) begin : g_flag
        ep_sticky_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (flag_set[gi]),
            .clr_i  (cmd[CMD_CLR_BASE + gi]),
            .flag_o (flag_q[gi])
        );
    end

    // pack the status vector
    always_comb begin
        rd_status                                   = '0;
        rd_status[STS_FULL]                         = (occ == occ_t'(SLOTS));
        rd_status[STS_ANY]                          = (occ != '0);
        rd_status[STS_FLAG_BASE +: FLAG_N]          = flag_q;
        rd_status[STS_TOG]                          = exp_tog;
    end

    assign rx_store = accept;
    assign hs_stall = flag_q[FLAG_STALL];

    p_ovr_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_start && cfg_iso && rd_status[STS_FULL]) |=> rd_status[STS_FLAG_BASE + FLAG_OVR]);
    p_stall_hs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_too_long |=> hs_stall);
    p_full_implies_any_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status[STS_FULL] |-> rd_status[STS_ANY]);
    p_drop_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status[STS_FULL] && !release_w) |-> !rx_store);
endmodule

// File: tb/test_usb_out_ep_ctrl.sv
module test_usb_out_ep_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_iso = 1'b0, tok_start = 1'b0, rx_ok = 1'b0, rx_pid1 = 1'b0;
    logic       rx_too_long = 1'b0, rx_iso_err = 1'b0, rx_busy = 1'b0, wr_en = 1'b0;
    logic [5:0] wr_data = '0;
    logic [5:0] rd_status;
    logic       rx_store, hs_stall;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    int m_occ;
    bit m_ovr, m_stl, m_derr, m_tog;

    always #2 clk = ~clk;   // 250 MHz

    usb_out_ep_ctrl i_usb_out_ep_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_iso(cfg_iso), .tok_start(tok_start),
        .rx_ok(rx_ok), .rx_pid1(rx_pid1), .rx_too_long(rx_too_long),
        .rx_iso_err(rx_iso_err), .rx_busy(rx_busy), .wr_en(wr_en),
        .wr_data(wr_data), .rd_status(rd_status), .rx_store(rx_store),
        .hs_stall(hs_stall)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit f_release(input bit we, input bit [5:0] c, input bit busy, input int occ);
        return (occ != 0) && we && (c[0] || (c[5] && !busy));
    endfunction

    function automatic bit f_accept(input bit ok, input bit pid, input bit tog, input int occ, input bit rel);
        return ok && (pid == tog) && (occ < 2 || rel);
    endfunction

    task automatic check_state(input string ctx);
        chk({ctx, " R2 two-sets bit0"}, rd_status[0], m_occ == 2);
        chk({ctx, " R2 any-set bit1"}, rd_status[1], m_occ != 0);
        chk({ctx, " R9 overrun bit2"}, rd_status[2], m_ovr);
        chk({ctx, " R10 stall bit3"}, rd_status[3], m_stl);
        chk({ctx, " R10 hs_stall"}, hs_stall, m_stl);
        chk({ctx, " R11 data-error bit4"}, rd_status[4], m_derr);
        chk({ctx, " R12 toggle bit5"}, rd_status[5], m_tog);
    endtask

    // one cycle: drive at negedge, check rx_store, update model, check state
    task automatic step(input string ctx, input bit iso, input bit tok, input bit ok,
                        input bit pid, input bit tl, input bit ie, input bit busy,
                        input bit we, input bit [5:0] c);
        bit rel, acc;
        cfg_iso = iso; tok_start = tok; rx_ok = ok; rx_pid1 = pid;
        rx_too_long = tl; rx_iso_err = ie; rx_busy = busy; wr_en = we; wr_data = c;
        rel = f_release(we, c, busy, m_occ);
        acc = f_accept(ok, pid, m_tog, m_occ, rel);
        #1;
        chk({ctx, " R3 rx_store"}, rx_store, acc);
        @(posedge clk);
        if (iso && tok && m_occ == 2) m_ovr = 1; else if (we && c[1]) m_ovr = 0;
        if (tl) m_stl = 1; else if (we && c[2]) m_stl = 0;
        if (iso && ie) m_derr = 1; else if (we && c[3]) m_derr = 0;
        if (we && c[4]) m_tog = 0; else if (acc) m_tog = ~m_tog;
        m_occ = m_occ + int'(acc) - int'(rel);
        @(negedge clk);
        cfg_iso = 0; tok_start = 0; rx_ok = 0; rx_too_long = 0;
        rx_iso_err = 0; rx_busy = 0; wr_en = 0; wr_data = '0;
        check_state(ctx);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_occ = 0; m_ovr = 0; m_stl = 0; m_derr = 0; m_tog = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset status", rd_status, 0);
        check_state("R1 reset");

        // R3: DATA0 then DATA1 fill both slots
        step("R3 fill0", 1, 0, 1, 0, 0, 0, 0, 0, 6'h00);
        step("R3 fill1", 1, 0, 1, 1, 0, 0, 0, 0, 6'h00);
        chk("R2 full status", rd_status, 6'b000011);
        // R5: matching packet while full is dropped
        step("R5 drop", 1, 0, 1, 0, 0, 0, 0, 0, 6'h00);
        // R9: token with two sets in iso mode; bulk mode does not set
        step("R9 bulk token", 0, 1, 0, 0, 0, 0, 0, 0, 6'h00);
        step("R9 iso token", 1, 1, 0, 0, 0, 0, 0, 0, 6'h00);
        step("R9 set wins clear", 1, 1, 0, 0, 0, 0, 0, 1, 6'h02);
        step("R9 clear", 1, 0, 0, 0, 0, 0, 0, 1, 6'h02);
        // R7: flush ignored while busy, then drops oldest of two
        step("R7 flush busy", 1, 0, 0, 0, 0, 0, 1, 1, 6'h20);
        step("R7 flush two", 1, 0, 0, 0, 0, 0, 0, 1, 6'h20);
        chk("R7 one left", rd_status[1:0], 2'b10);
        // R8: reception with simultaneous unload keeps count
        step("R8 rx+unload", 1, 0, 1, 0, 0, 0, 0, 1, 6'h01);
        // R4: mismatched PID ignored
        step("R4 mismatch", 1, 0, 1, 0, 0, 0, 0, 0, 6'h00);
        // R6: unload to empty, then unload/flush on empty ignored
        step("R6 unload", 1, 0, 0, 0, 0, 0, 0, 1, 6'h01);
        step("R6 unload empty", 1, 0, 0, 0, 0, 0, 0, 1, 6'h01);
        step("R7 flush empty", 1, 0, 0, 0, 0, 0, 0, 1, 6'h20);
        chk("R6 empty", rd_status[1:0], 2'b00);
        // R12: init wins over accept in the same cycle
        step("R12 init+accept", 1, 0, 1, 1, 0, 0, 0, 1, 6'h10);
        chk("R12 toggle data0", rd_status[5], 0);
        // R10 / R11
        step("R10 too long", 1, 0, 0, 0, 1, 0, 0, 0, 6'h00);
        step("R10 clear", 1, 0, 0, 0, 0, 0, 0, 1, 6'h04);
        step("R11 bulk err", 0, 0, 0, 0, 0, 1, 0, 0, 6'h00);
        step("R11 iso err", 1, 0, 0, 0, 0, 1, 0, 0, 6'h00);
        step("R11 clear", 1, 0, 0, 0, 0, 0, 0, 1, 6'h08);

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            bit iso, tok, ok, pid, tl, ie, busy, we;
            bit [5:0] c;
            iso  = ($urandom % 4) != 0;
            tok  = ($urandom % 4) == 0;
            tl   = ($urandom % 16) == 0;
            ok   = !tl && (($urandom % 3) == 0);
            pid  = (($urandom % 4) == 0) ? ~m_tog : m_tog;
            ie   = ($urandom % 12) == 0;
            busy = ($urandom % 4) == 0;
            we   = ($urandom % 3) == 0;
            c    = 6'($urandom);
            if (($urandom % 2) == 0) c[4] = 0;
            step("rand", iso, tok, ok, pid, tl, ie, busy, we, c);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule